// File: doc/BRIEF.md
# Autonegotiation Result Validator

This block sits beside an Ethernet PHY's autonegotiation logic and decides whether a result that is reported as finished can be trusted. Every time autonegotiation is enabled and the complete indication rises, the block looks at the link-partner ability word, the partner-capable bit from the expansion register, and an internal flag that shows whether the partner's data was latched correctly. A good result is accepted: the block gives a one-cycle strobe and holds a copy of the ability word. A corrupt result causes a one-cycle restart request.

Two silent failures are caught. In the first, the internal valid flag is clear even though negotiation claims to be done. In the second, the partner is known to negotiate but its ability word has no acknowledge bit. A typical case is a word of 0x0001, which means the local base page was probably never sent. Restarts are counted. When all allowed retries have been used, the block raises a sticky failure flag and stops restarting until autonegotiation is disabled or the block is reset.

Top module: `an_validator`

## Requirements
- R1: No check is made, and neither restart_o nor result_valid_o pulses, while an_enable_i is low, even if an_complete_i rises.
- R2: A check made while lp_valid_i is 0 is invalid and leads to a restart (or to failure, see R8), whatever the ability word holds.
- R3: A check made while lp_an_capable_i is 1 and bit 14 (acknowledge) of lp_ability_i is 0 is invalid, for example with the word 0x0001. When lp_an_capable_i is 0, a clear bit 14 alone does not make the result invalid.
- R4: A valid check (lp_valid_i is 1 and R3 does not apply) pulses result_valid_o for one cycle and loads lp_ability_i into ability_o. It also clears retry_cnt_o.
- R5: Outputs are registered. restart_o or result_valid_o is high in the cycle after the check cycle, for exactly one cycle, and the two are never high together.
- R6: Each rising of an_complete_i (while enabled) gives at most one check. Holding an_complete_i high produces no further checks, and a new check needs an_complete_i to go low and then high again.
- R7: Each restart adds one to retry_cnt_o, which never exceeds MAX_RETRY (default 6).
- R8: An invalid check made while retry_cnt_o equals MAX_RETRY sets fail_o and gives no restart. While fail_o is set, no checks are made and fail_o stays set.
- R9: Driving an_enable_i low clears retry_cnt_o and fail_o on the next clock edge.
- R10: After reset, restart_o, result_valid_o, fail_o, retry_cnt_o and ability_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| an_enable_i | input | 1 | Autonegotiation enabled |
| an_complete_i | input | 1 | Autonegotiation reports complete |
| lp_ability_i | input | WORD_W | Link-partner ability word (bit 14 = acknowledge) |
| lp_an_capable_i | input | 1 | Expansion register: partner can autonegotiate |
| lp_valid_i | input | 1 | Internal flag: partner data latched correctly |
| restart_o | output | 1 | One-cycle autonegotiation restart request |
| result_valid_o | output | 1 | One-cycle strobe: result accepted |
| ability_o | output | WORD_W | Last accepted ability word |
| retry_cnt_o | output | CNT_W | Restarts since the last accept or disable |
| fail_o | output | 1 | Sticky: retries exhausted |

## Verification
The assertions assume that the ability word, the capable bit and the valid flag are stable in the cycle in which the complete indication rises. They also assume that a disable lasts at least one clock edge. The bench meets both by changing every input only at the falling clock edge, and by setting the status inputs together with an_complete_i. Each check then holds an_complete_i high for one more cycle and drops it for one cycle before the next check. This lets the one-check-per-rising rule be tested while the inputs follow the same handshake a real PHY would present.

// File: rtl/an_validator_pkg.sv
package an_validator_pkg;
  localparam int ACK_BIT = 14;

  typedef enum logic [1:0] {
    VERDICT_IDLE,
    VERDICT_ACCEPT,
    VERDICT_RETRY,
    VERDICT_GIVE_UP
  } verdict_e;
endpackage

// File: rtl/an_arm.sv
// Permits one check per rising of the complete indication.
module an_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic complete_i,
  input  logic consume_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b1;
    else if (!complete_i) armed_q <= 1'b1;
    else if (consume_i)   armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/an_classify.sv
module an_classify #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] ability_i,
  input  logic              capable_i,
  input  logic              lp_valid_i,
  output logic              bad_flag_o,
  output logic              bad_ack_o,
  output logic              invalid_o
);
  import an_validator_pkg::*;

  // Late failure: the data looks plausible but the internal flag disagrees.
  assign bad_flag_o = !lp_valid_i;
  // Early failure: the partner negotiates but never acknowledged our page.
  assign bad_ack_o  = capable_i && !ability_i[ACK_BIT];
  assign invalid_o  = bad_flag_o || bad_ack_o;
endmodule

// File: rtl/an_retry_ctrl.sv
module an_retry_ctrl #(
  parameter int MAX_RETRY = 6,
  parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             check_i,
  input  logic             invalid_i,
  output logic             restart_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fail_o
);
  import an_validator_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

  verdict_e         verdict;
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q, restart_q, accept_q;

  always_comb begin
    verdict = VERDICT_IDLE;
    if (check_i) begin
      if (!invalid_i)          verdict = VERDICT_ACCEPT;
      else if (cnt_q < CNT_MAX) verdict = VERDICT_RETRY;
      else                     verdict = VERDICT_GIVE_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      fail_q    <= 1'b0;
      restart_q <= 1'b0;
      accept_q  <= 1'b0;
    end else begin
      restart_q <= (verdict == VERDICT_RETRY);
      accept_q  <= (verdict == VERDICT_ACCEPT);
      if (!enable_i) begin
        cnt_q  <= '0;
        fail_q <= 1'b0;
      end else begin
        unique case (verdict)
          VERDICT_ACCEPT:  cnt_q  <= '0;
          VERDICT_RETRY:   cnt_q  <= cnt_q + 1'b1;
          VERDICT_GIVE_UP: fail_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign restart_o = restart_q;
  assign accept_o  = accept_q;
  assign cnt_o     = cnt_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/an_validator.sv
module an_validator #(
  parameter int WORD_W    = 16,
  parameter int MAX_RETRY = 6,
  localparam int CNT_W    = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              an_enable_i,
  input  logic              an_complete_i,
  input  logic [WORD_W-1:0] lp_ability_i,
  input  logic              lp_an_capable_i,
  input  logic              lp_valid_i,
  output logic              restart_o,
  output logic              result_valid_o,
  output logic [WORD_W-1:0] ability_o,
  output logic [CNT_W-1:0]  retry_cnt_o,
  output logic              fail_o
);
  logic armed, check, invalid, bad_flag, bad_ack, accept;
  logic [WORD_W-1:0] ability_q;

  an_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .complete_i (an_complete_i),
    .consume_i  (check),
    .armed_o    (armed)
  );

  assign check = an_enable_i && an_complete_i && armed && !fail_o;

  an_classify #(.WORD_W(WORD_W)) u_classify (
    .ability_i  (lp_ability_i),
    .capable_i  (lp_an_capable_i),
    .lp_valid_i (lp_valid_i),
    .bad_flag_o (bad_flag),
    .bad_ack_o  (bad_ack),
    .invalid_o  (invalid)
  );

  an_retry_ctrl #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_retry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (an_enable_i),
    .check_i   (check),
    .invalid_i (invalid),
    .restart_o (restart_o),
    .accept_o  (accept),
    .cnt_o     (retry_cnt_o),
    .fail_o    (fail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ability_q <= '0;
    else if (check && !invalid)  ability_q <= lp_ability_i;
  end

  assign result_valid_o = accept;
  assign ability_o      = ability_q;
endmodule

// File: rtl/an_validator_chk.sv
module an_validator_chk #(
  parameter int MAX_RETRY = 6,
  parameter int CNT_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             an_enable_i,
  input logic             restart_o,
  input logic             result_valid_o,
  input logic [CNT_W-1:0] retry_cnt_o,
  input logic             fail_o
);
  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_enable_i |=> (!restart_o && !result_valid_o));

  assert_accept_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (retry_cnt_o == '0));

  assert_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_o && result_valid_o));

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (retry_cnt_o == $past(retry_cnt_o) + 1'b1));

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= CNT_W'(MAX_RETRY));

  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && an_enable_i) |=> fail_o);

  assert_fail_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !restart_o);

  assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_enable_i |=> (!fail_o && retry_cnt_o == '0));
endmodule

bind an_validator an_validator_chk #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .an_enable_i    (an_enable_i),
  .restart_o      (restart_o),
  .result_valid_o (result_valid_o),
  .retry_cnt_o    (retry_cnt_o),
  .fail_o         (fail_o)
);

// File: tb/an_validator_tb_top.sv
module an_validator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_RETRY  = 6;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        an_enable_i = 1'b0, an_complete_i = 1'b0;
  logic [15:0] lp_ability_i = '0;
  logic        lp_an_capable_i = 1'b0, lp_valid_i = 1'b0;
  logic        restart_o, result_valid_o, fail_o;
  logic [15:0] ability_o;
  logic [2:0]  retry_cnt_o;

  int checks = 0, errors = 0;
  int m_cnt = 0;
  bit m_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  an_validator dut_i (
    .clk_i, .rst_ni, .an_enable_i, .an_complete_i, .lp_ability_i,
    .lp_an_capable_i, .lp_valid_i, .restart_o, .result_valid_o,
    .ability_o, .retry_cnt_o, .fail_o
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_enable(input logic v);
    an_enable_i = v;
    @(negedge clk_i);
    if (!v) begin m_cnt = 0; m_fail = 0; end
  endtask

  // One complete pulse: rise, hold one extra cycle, drop.
  task automatic run_check(input logic lpv, input logic cap, input logic [15:0] ab,
                           input string tag);
    bit bad, e_rs, e_ok;
    e_rs = 0; e_ok = 0;
    bad = !lpv || (cap && !ab[14]);
    if (an_enable_i && !m_fail) begin
      if (!bad) begin e_ok = 1; m_cnt = 0; end
      else if (m_cnt < MAX_RETRY) begin e_rs = 1; m_cnt++; end
      else m_fail = 1;
    end
    lp_valid_i = lpv; lp_an_capable_i = cap; lp_ability_i = ab;
    an_complete_i = 1'b1;
    @(negedge clk_i);
    chk(restart_o, e_rs, tag, "restart");
    chk(result_valid_o, e_ok, tag, "result_valid");
    chk(retry_cnt_o, m_cnt, tag, "retry_cnt");
    chk(fail_o, m_fail, tag, "fail");
    if (e_ok) chk(ability_o, ab, tag, "ability");
    @(negedge clk_i);
    chk(restart_o, 0, "R5/R6", "restart held");
    chk(result_valid_o, 0, "R5/R6", "valid held");
    an_complete_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0001; pats[1] = 16'h4001; pats[2] = 16'hC5E1; pats[3] = 16'h01E1;
    repeat (3) @(negedge clk_i);
    // R10
    chk(restart_o, 0, "R10", "restart");
    chk(result_valid_o, 0, "R10", "valid");
    chk(fail_o, 0, "R10", "fail");
    chk(retry_cnt_o, 0, "R10", "cnt");
    chk(ability_o, 0, "R10", "ability");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Sweep of flag, capable bit and ability patterns (R2, R3, R4)
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 4; p++) begin
          set_enable(1'b0);
          set_enable(1'b1);
          run_check(v[0], c[0], pats[p], v == 0 ? "R2" : (c == 1 ? "R3" : "R4"));
        end

    // Retries up to the limit, then give up (R7, R8)
    set_enable(1'b0);
    set_enable(1'b1);
    for (int i = 0; i < MAX_RETRY; i++) run_check(1'b1, 1'b1, 16'h0001, "R7");
    run_check(1'b1, 1'b1, 16'h0001, "R8");
    run_check(1'b1, 1'b0, 16'h41E1, "R8");  // valid input ignored while failed
    chk(fail_o, 1, "R8", "fail sticky");

    // Disable clears (R9)
    set_enable(1'b0);
    chk(fail_o, 0, "R9", "fail");
    chk(retry_cnt_o, 0, "R9", "cnt");

    // Disabled: complete ignored (R1)
    run_check(1'b0, 1'b1, 16'h0001, "R1");
    run_check(1'b1, 1'b0, 16'h41E1, "R1");

    // Accept after some retries clears count (R4)
    set_enable(1'b1);
    for (int i = 0; i < 3; i++) run_check(1'b0, 1'b0, 16'h41E1, "R7");
    run_check(1'b1, 1'b1, 16'h45E1, "R4");

    // Held complete: one check only (R6)
    lp_valid_i = 1'b0; an_complete_i = 1'b1;
    @(negedge clk_i);
    chk(restart_o, 1, "R6", "first restart");
    repeat (4) begin
      @(negedge clk_i);
      chk(restart_o, 0, "R6", "no recheck");
    end
    chk(retry_cnt_o, 1, "R6", "cnt");
    an_complete_i = 1'b0;
    @(negedge clk_i);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule